// File: doc/BRIEF.md
# Receive frame buffer with length descriptor

This block sits between a MAC receive engine and a bus-side reader. The engine hands over one byte per valid cycle and marks the first and last byte of each frame with start and end strobes. Frames are held in a parameterised FIFO and become visible to the reader only once their end strobe has been accepted. Several frames can wait in the FIFO while the reader is not being served.

The reader drains bytes with a valid/ready handshake. While it does so, the block counts the delivered bytes of the frame in a saturating length counter. One cycle after the last byte is taken, the block emits a descriptor word. The word holds the length, start and end marks, and the status that the engine supplied with the end strobe.

A strip control, sampled at each start strobe, removes the trailing four check bytes of a frame. A diagnostic register captures the status of every frame end, including frames that were dropped because the FIFO overflowed.

Top module: `rxf_frame_buffer`

## Requirements
- R1: Frames whose bytes all fit in the FIFO are all kept, and they are delivered in arrival order with their byte order unchanged, even while `rd_ready` stays low.
- R2: A byte becomes visible on `rd_valid`/`rd_data` only after its frame's end strobe has been accepted. `rd_data` and `rd_last` hold steady while `rd_valid` is high and `rd_ready` is low. `rd_last` is 1 on the final delivered byte of each frame.
- R3: The length counts the bytes delivered for the frame and saturates at 2^LEN_W-1 (0xFFFF at the default LEN_W of 16) instead of wrapping.
- R4: `desc_valid` pulses for one cycle, in the cycle after the last byte of a frame is taken. `desc_word` carries the length in bits [LEN_W-1:0], the start mark (1) in bit LEN_W, the end mark (1) in bit LEN_W+1, the overflow flag in bit LEN_W+2, and above it the `rx_status` value sampled with the end strobe.
- R5: With strip off at the start strobe, every byte of the frame, trailing check bytes included, is delivered and counted.
- R6: With strip on at the start strobe, the last 4 bytes of the frame are neither delivered nor counted. A frame of 4 bytes or fewer then yields no data and no descriptor. Changing `strip_crc` in the middle of a frame has no effect on that frame.
- R7: `diag_status` is loaded with {`rx_status`, overflow flag in bit 0} at every accepted end strobe and keeps its value otherwise.
- R8: A byte that must be stored while the FIFO holds DEPTH entries causes the whole frame to be dropped. No data and no descriptor are produced for it, `diag_status` bit 0 reads 1 after its end strobe, and later frames are unaffected.
- R9: Bytes that arrive outside a frame, that is without a preceding start strobe, are ignored.
- R10: A start strobe inside an open frame discards the partial frame and begins a new one with that byte.
- R11: After reset `rd_valid` and `desc_valid` are 0 and `diag_status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strip_crc | input | 1 | Remove trailing check bytes; sampled at start strobe |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | First byte of frame |
| rx_eof | input | 1 | Last byte of frame |
| rx_data | input | 8 | Receive byte |
| rx_status | input | ST_W | Frame status, sampled with end strobe |
| rd_ready | input | 1 | Reader takes the byte on offer |
| rd_valid | output | 1 | A committed byte is on offer |
| rd_data | output | 8 | Byte on offer |
| rd_last | output | 1 | Byte on offer ends its frame |
| desc_valid | output | 1 | Descriptor strobe |
| desc_word | output | LEN_W+ST_W+3 | Descriptor: length, marks, status |
| diag_status | output | ST_W+1 | Status of the latest frame end |

## Verification
The bench attacks the FIFO boundary in two ways. A frame that fills the FIFO exactly must survive. A frame one byte larger must vanish completely. A design that kept the partial frame would offer bytes that never end, and one that missed the full condition would overwrite frames that were still unread. Strip mode is probed at lengths 3, 4, 5 and 9, where an off-by-one in the hold stage either leaks a check byte or wrongly drops a 5-byte frame. Length saturation is hit both exactly and beyond the limit, where a wrapping counter would report a small value. Loose bytes, restarts inside a frame and a mid-frame strip change check that no stray data or wrong mode leaks into the next frame.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   localparam int unsigned RXF_BYTE_W    = 8;
   localparam int unsigned RXF_CRC_BYTES = 4;
endpackage

// File: rtl/rxf_crc_hold.sv
module rxf_crc_hold #(
   parameter int unsigned HOLD = rxf_pkg::RXF_CRC_BYTES
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   input  logic                          in_sof,
   input  logic                          in_eof,
   input  logic [rxf_pkg::RXF_BYTE_W-1:0] in_data,
   input  logic                          strip_cfg,
   output logic                          out_valid,
   output logic [rxf_pkg::RXF_BYTE_W-1:0] out_data
);
   localparam int unsigned FW = $clog2(HOLD + 1);
   localparam logic [FW-1:0] FILL_MAX = FW'(HOLD);

   logic [rxf_pkg::RXF_BYTE_W-1:0] dl [HOLD];
   logic [FW-1:0] fill_q, fill_now;
   logic          mode_q, mode_now, shift;

   always_comb begin
      mode_now  = in_sof ? strip_cfg : mode_q;
      fill_now  = in_sof ? '0 : fill_q;
      out_valid = in_valid && (!mode_now || fill_now == FILL_MAX);
      out_data  = mode_now ? dl[HOLD-1] : in_data;
      shift     = in_valid && mode_now && !in_eof;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         fill_q <= '0;
      end else if (in_valid) begin
         mode_q <= mode_now;
         if (in_eof || !mode_now)
            fill_q <= '0;
         else if (fill_now != FILL_MAX)
            fill_q <= fill_now + 1'b1;
         else
            fill_q <= fill_now;
      end
   end

   always_ff @(posedge clk) begin
      if (shift) begin
         dl[0] <= in_data;
         for (int i = 1; i < int'(HOLD); i++)
            dl[i] <= dl[i-1];
      end
   end
endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned EW    = 13,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [EW-1:0] in_entry,
   input  logic          frame_start,
   input  logic          frame_end,
   input  logic [AW:0]   rd_ptr,
   output logic [AW:0]   cm_ptr,
   output logic [EW-1:0] rd_entry,
   output logic          ovf_any
);
   localparam logic [AW:0] FULL_OCC = (AW+1)'(DEPTH);

   logic [EW-1:0] mem [DEPTH];
   logic [AW:0]   wp_q, cp_q, base, occ, wp_nxt;
   logic          ovf_q, ovf_now, attempt, full, wr_en, ovf_set;

   always_comb begin
      base    = frame_start ? cp_q : wp_q;
      ovf_now = frame_start ? 1'b0 : ovf_q;
      occ     = base - rd_ptr;
      full    = (occ == FULL_OCC);
      attempt = in_valid && !ovf_now;
      wr_en   = attempt && !full;
      ovf_set = attempt && full;
      ovf_any = ovf_now || ovf_set;
      wp_nxt  = base + {{AW{1'b0}}, wr_en};
   end

   always_ff @(posedge clk) begin
      if (wr_en)
         mem[base[AW-1:0]] <= in_entry;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q  <= '0;
         cp_q  <= '0;
         ovf_q <= 1'b0;
      end else if (frame_end) begin
         ovf_q <= 1'b0;
         if (ovf_any) begin
            wp_q <= cp_q;
         end else begin
            wp_q <= wp_nxt;
            cp_q <= wp_nxt;
         end
      end else begin
         wp_q  <= wp_nxt;
         ovf_q <= ovf_any;
      end
   end

   assign cm_ptr   = cp_q;
   assign rd_entry = mem[rd_ptr[AW-1:0]];
endmodule

// File: rtl/rxf_reader.sv
module rxf_reader #(
   parameter int unsigned AW    = 6,
   parameter int unsigned LEN_W = 16,
   parameter int unsigned SW    = 4,
   localparam int unsigned BW   = rxf_pkg::RXF_BYTE_W,
   localparam int unsigned EW   = BW + SW + 1,
   localparam int unsigned DW   = LEN_W + 2 + SW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW:0]   cm_ptr,
   input  logic [EW-1:0] rd_entry,
   input  logic          rd_ready,
   output logic [AW:0]   rd_ptr,
   output logic          rd_valid,
   output logic [BW-1:0] rd_data,
   output logic          rd_last,
   output logic          desc_valid,
   output logic [DW-1:0] desc_word
);
   logic [AW:0]    rp_q;
   logic [LEN_W-1:0] len_q, len_inc;
   logic [SW-1:0]  ent_stat;
   logic           pop;

   always_comb begin
      rd_valid = (rp_q != cm_ptr);
      rd_data  = rd_entry[BW-1:0];
      ent_stat = rd_entry[BW+SW-1:BW];
      rd_last  = rd_entry[EW-1];
      pop      = rd_valid && rd_ready;
      len_inc  = (&len_q) ? len_q : len_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rp_q       <= '0;
         len_q      <= '0;
         desc_valid <= 1'b0;
         desc_word  <= '0;
      end else begin
         desc_valid <= 1'b0;
         if (pop) begin
            rp_q <= rp_q + 1'b1;
            if (rd_last) begin
               len_q      <= '0;
               desc_valid <= 1'b1;
               desc_word  <= {ent_stat, 1'b1, 1'b1, len_inc};
            end else begin
               len_q <= len_inc;
            end
         end
      end
   end

   assign rd_ptr = rp_q;
endmodule

// File: rtl/rxf_frame_buffer.sv
module rxf_frame_buffer #(
   parameter int unsigned DEPTH     = 64,
   parameter int unsigned LEN_W     = 16,
   parameter int unsigned ST_W      = 8,
   parameter int unsigned CRC_BYTES = rxf_pkg::RXF_CRC_BYTES,
   localparam int unsigned BW       = rxf_pkg::RXF_BYTE_W,
   localparam int unsigned SW       = ST_W + 1,
   localparam int unsigned EW       = BW + SW + 1,
   localparam int unsigned AW       = $clog2(DEPTH),
   localparam int unsigned DW       = LEN_W + 2 + SW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            strip_crc,
   input  logic            rx_valid,
   input  logic            rx_sof,
   input  logic            rx_eof,
   input  logic [BW-1:0]   rx_data,
   input  logic [ST_W-1:0] rx_status,
   input  logic            rd_ready,
   output logic            rd_valid,
   output logic [BW-1:0]   rd_data,
   output logic            rd_last,
   output logic            desc_valid,
   output logic [DW-1:0]   desc_word,
   output logic [SW-1:0]   diag_status
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("rxf_frame_buffer: DEPTH must be a power of two >= 2");
      end
      if (LEN_W < 2 || LEN_W > 32) begin : g_bad_len
         $error("rxf_frame_buffer: LEN_W out of range");
      end
      if (CRC_BYTES < 1 || ST_W < 1) begin : g_bad_opt
         $error("rxf_frame_buffer: CRC_BYTES and ST_W must be >= 1");
      end
   endgenerate

   logic          in_frame_q, acc, f_start, f_end;
   logic          h_valid, ovf_any;
   logic [BW-1:0] h_data;
   logic [AW:0]   rd_ptr, cm_ptr;
   logic [EW-1:0] rd_entry, wr_entry;

   always_comb begin
      acc      = rx_valid && (rx_sof || in_frame_q);
      f_start  = acc && rx_sof;
      f_end    = acc && rx_eof;
      wr_entry = {rx_eof, rx_status, 1'b0, h_data};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_frame_q  <= 1'b0;
         diag_status <= '0;
      end else if (acc) begin
         in_frame_q <= !rx_eof;
         if (rx_eof)
            diag_status <= {rx_status, ovf_any};
      end
   end

   rxf_crc_hold #(.HOLD(CRC_BYTES)) hold_i (
      .clk(clk), .rst_n(rst_n), .in_valid(acc), .in_sof(rx_sof),
      .in_eof(rx_eof), .in_data(rx_data), .strip_cfg(strip_crc),
      .out_valid(h_valid), .out_data(h_data)
   );

   rxf_store #(.DEPTH(DEPTH), .EW(EW)) store_i (
      .clk(clk), .rst_n(rst_n), .in_valid(h_valid), .in_entry(wr_entry),
      .frame_start(f_start), .frame_end(f_end), .rd_ptr(rd_ptr),
      .cm_ptr(cm_ptr), .rd_entry(rd_entry), .ovf_any(ovf_any)
   );

   rxf_reader #(.AW(AW), .LEN_W(LEN_W), .SW(SW)) reader_i (
      .clk(clk), .rst_n(rst_n), .cm_ptr(cm_ptr), .rd_entry(rd_entry),
      .rd_ready(rd_ready), .rd_ptr(rd_ptr), .rd_valid(rd_valid),
      .rd_data(rd_data), .rd_last(rd_last), .desc_valid(desc_valid),
      .desc_word(desc_word)
   );
endmodule

// File: rtl/rxf_frame_buffer_chk.sv
module rxf_frame_buffer_chk #(
   parameter int unsigned LEN_W = 16,
   parameter int unsigned ST_W  = 8,
   localparam int unsigned DW   = LEN_W + ST_W + 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            rx_valid,
   input logic            rx_sof,
   input logic            rx_eof,
   input logic            frm_open,
   input logic            rd_ready,
   input logic            rd_valid,
   input logic [7:0]      rd_data,
   input logic            rd_last,
   input logic            desc_valid,
   input logic [DW-1:0]   desc_word,
   input logic [ST_W:0]   diag_status
);
   // R2
   hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && !rd_ready |=> rd_valid && $stable(rd_data) && $stable(rd_last));

   // R4
   desc_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |-> $past(rd_valid && rd_ready && rd_last));

   // R4
   desc_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |-> desc_word[LEN_W+1:LEN_W] == 2'b11);

   // R3
   len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |-> desc_word[LEN_W-1:0] != '0);

   // R8
   no_ovf_delivered_chk: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |-> !desc_word[LEN_W+2]);

   // R7
   diag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_valid && rx_eof && (rx_sof || frm_open)) |=> $stable(diag_status));
endmodule

bind rxf_frame_buffer rxf_frame_buffer_chk #(.LEN_W(LEN_W), .ST_W(ST_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
   .rx_eof(rx_eof), .frm_open(in_frame_q), .rd_ready(rd_ready),
   .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
   .desc_valid(desc_valid), .desc_word(desc_word), .diag_status(diag_status)
);

// File: tb/rxf_frame_buffer_tb.sv
module rxf_frame_buffer_tb_top;
   localparam int DEPTH = 32;
   localparam int LEN_W = 4;
   localparam int ST_W  = 3;
   localparam int CRCN  = 4;
   localparam int DW    = LEN_W + ST_W + 3;
   localparam logic [LEN_W-1:0] LMAX = '1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic strip_crc = 1'b0, rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
   logic [7:0] rx_data = '0;
   logic [ST_W-1:0] rx_status = '0;
   logic rd_ready = 1'b0;
   logic rd_valid, rd_last, desc_valid;
   logic [7:0] rd_data;
   logic [DW-1:0] desc_word;
   logic [ST_W:0] diag_status;

   int n_cmp = 0, n_bad = 0, cyc = 0, rdy_mode = 0;
   string phase = "R11 reset";

   always #5 clk = ~clk;

   rxf_frame_buffer #(.DEPTH(DEPTH), .LEN_W(LEN_W), .ST_W(ST_W), .CRC_BYTES(CRCN)) dut_i (
      .clk(clk), .rst_n(rst_n), .strip_crc(strip_crc), .rx_valid(rx_valid),
      .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data), .rx_status(rx_status),
      .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
      .desc_valid(desc_valid), .desc_word(desc_word), .diag_status(diag_status)
   );

   // reference model: entry = {last, status, ovf, data}
   logic [12:0] q[$], pend[$];
   logic [7:0]  hold[$];
   logic        m_in, m_mode, m_ovf, e_dv, have;
   logic [LEN_W-1:0] m_len;
   logic [DW-1:0] e_desc;
   logic [ST_W:0] e_diag;
   logic [12:0] ent;
   logic [7:0]  b;
   int qsz;

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete(); pend.delete(); hold.delete();
         m_in = 0; m_mode = 0; m_ovf = 0; m_len = '0;
         e_dv = 0; e_desc = '0; e_diag = '0;
      end else begin
         qsz = q.size();
         e_dv = 0;
         if (qsz > 0 && rd_ready) begin
            ent = q.pop_front();
            m_len = (m_len == LMAX) ? LMAX : m_len + 1'b1;
            if (ent[12]) begin
               e_dv = 1;
               e_desc = {ent[11:8], 2'b11, m_len};
               m_len = '0;
            end
         end
         if (rx_valid && (rx_sof || m_in)) begin
            if (rx_sof) begin
               pend.delete(); hold.delete(); m_mode = strip_crc; m_ovf = 0;
            end
            have = 0; b = '0;
            if (!m_mode) begin
               have = 1; b = rx_data;
            end else begin
               if (hold.size() == CRCN) begin
                  have = 1; b = hold.pop_front();
               end
               if (!rx_eof) hold.push_back(rx_data);
            end
            if (have && !m_ovf) begin
               if (qsz + pend.size() == DEPTH) m_ovf = 1;
               else pend.push_back({rx_eof, rx_status, 1'b0, b});
            end
            if (rx_eof) begin
               e_diag = {rx_status, m_ovf};
               if (!m_ovf) foreach (pend[i]) q.push_back(pend[i]);
               pend.delete(); hold.delete();
               m_in = 0; m_ovf = 0;
            end else begin
               m_in = 1;
            end
         end
      end
   end

   task automatic check(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL [%s] %s actual %h expected %h", phase, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      if (rdy_mode == 2) rd_ready = 1'($urandom % 2);
      else rd_ready = 1'(rdy_mode);
      if (rst_n) begin
         check(rd_valid == (q.size() > 0), "R1/R2 rd_valid", 32'(rd_valid), 32'(q.size() > 0));
         if (q.size() > 0) begin
            check(rd_data == q[0][7:0], "R1/R5/R6 rd_data", 32'(rd_data), 32'(q[0][7:0]));
            check(rd_last == q[0][12], "R2 rd_last", 32'(rd_last), 32'(q[0][12]));
         end
         check(desc_valid == e_dv, "R4 desc_valid", 32'(desc_valid), 32'(e_dv));
         if (e_dv)
            check(desc_word == e_desc, "R3/R4 desc_word", 32'(desc_word), 32'(e_desc));
         check(diag_status == e_diag, "R7 diag_status", 32'(diag_status), 32'(e_diag));
      end
      if (cyc > 150000) begin
         n_cmp++; n_bad++;
         $display("FAIL [%s] watchdog actual %0d expected <150000", phase, cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // restart_at >= 0 raises a second start strobe at that byte index
   task automatic send(input int n, input logic strip, input logic [ST_W-1:0] st,
                       input int restart_at = -1, input int flip_at = -1);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rx_valid = 1; rx_sof = (i == 0) || (i == restart_at);
         rx_eof = (i == n - 1); rx_data = 8'($urandom);
         rx_status = st;
         strip_crc = (i == flip_at) ? ~strip : strip;
      end
      @(negedge clk);
      rx_valid = 0; rx_sof = 0; rx_eof = 0;
   endtask

   initial begin
      idle(4);
      check(rd_valid == 0, "R11 rd_valid in reset", 32'(rd_valid), 0);
      check(desc_valid == 0, "R11 desc_valid in reset", 32'(desc_valid), 0);
      check(diag_status == 0, "R11 diag in reset", 32'(diag_status), 0);
      rst_n = 1;
      idle(2);

      phase = "R1 R5 accumulate";
      rdy_mode = 0;
      send(3, 0, 3'd1); send(7, 0, 3'd2); send(1, 0, 3'd5);
      idle(3);
      check(rd_valid == 1, "R1 frames waiting", 32'(rd_valid), 1);
      rdy_mode = 1; idle(20);

      phase = "R6 strip";
      send(6, 1, 3'd3); send(5, 1, 3'd4); send(3, 1, 3'd6); send(4, 1, 3'd7);
      send(9, 1, 3'd2, -1, 4);
      idle(20);

      phase = "R9 loose bytes";
      for (int i = 0; i < 5; i++) begin
         @(negedge clk); rx_valid = 1; rx_sof = 0; rx_eof = (i == 4); rx_data = 8'(i);
      end
      @(negedge clk); rx_valid = 0; rx_eof = 0;
      idle(3);
      check(rd_valid == 0, "R9 nothing stored", 32'(rd_valid), 0);

      phase = "R10 restart";
      send(8, 0, 3'd1, 3); send(10, 1, 3'd2, 2);
      idle(20);

      phase = "R8 overflow";
      rdy_mode = 0;
      send(10, 0, 3'd1); send(10, 0, 3'd2); send(14, 0, 3'd3);
      idle(2);
      check(diag_status[0] == 1, "R8 overflow flag", 32'(diag_status), 32'(1));
      send(12, 0, 3'd4);
      idle(2);
      check(diag_status[0] == 0, "R8 exact fit kept", 32'(diag_status), 32'(0));
      rdy_mode = 1; idle(40);

      phase = "R3 saturation";
      send(20, 0, 3'd1); send(20, 1, 3'd2); send(19, 1, 3'd3); send(15, 0, 3'd4);
      send(16, 0, 3'd5);
      idle(30);

      phase = "R1 R2 random";
      rdy_mode = 2;
      for (int k = 0; k < 40; k++) begin
         send(1 + int'($urandom % 12), 1'($urandom % 2), 3'($urandom));
         idle(int'($urandom % 4));
      end
      rdy_mode = 1; idle(80);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule